// File: doc/BRIEF.md
# Shared-Pin Two-Wire / Four-Wire Register Slave

This block puts a 128-byte register file behind one set of serial pins that either an I2C master or a four-wire SPI master can use. The four pins are data-in, clock, address strap / serial data out, and an active-low select. The I2C side waits for a START condition and matches a 7-bit slave address whose lowest bit comes from the strap pin. It then acknowledges, takes a register pointer, and writes or reads bytes, moving the pointer on after each byte. The SPI side works only while the select is low. It uses a command byte followed by a data burst in which the address also moves on after each byte.

All pins are sampled into the system clock through two-flop synchronizers, and edges are found on the synchronized copies. The system clock must run at least 16 times faster than the serial clock. One configuration bit in the register file turns the I2C decoder off, so that SPI traffic on the shared data and clock pins is never taken for I2C framing. The open-drain pad is outside the block: `sda_oe_o` high means the pad pulls the data line low.

Top module: `dual_serial_regslave`

## Requirements
- R1: The I2C slave address is 7 bits, binary 110100 followed by the level of `strap_i`. Only a matching address byte is acknowledged, by holding the data line low during the ninth clock. The lowest bit of that byte is the direction: 0 means write, 1 means read.
- R2: START is data falling while the clock is high, and STOP is data rising while the clock is high. The bus is busy from START until STOP. Clock pulses outside a busy period are ignored and never acknowledged.
- R3: An I2C write carries the address with direction 0, then one pointer byte whose low 7 bits select the register, then data bytes. Each data byte is stored at the pointer, the pointer then increments, and every byte is acknowledged.
- R4: An I2C read (a repeated START, then the address with direction 1) sends bytes MSB first, starting at the current pointer and incrementing after each byte. A master ACK (data low) asks for the next byte. A master NACK ends the transfer, and the slave releases the data line.
- R5: A STOP that arrives partway through an I2C data byte discards that byte, so no register changes.
- R6: While SPI select is low, the first byte is a command: bit 7 = 1 means read, and bits 6:0 are the start address. On a write, each following byte is stored at the address, which then increments. Data are sampled on rising SCLK edges, MSB first.
- R7: On an SPI read, data go out MSB first and change only after falling SCLK edges. The first bit is valid at the first rising edge after the command byte, and the address increments per byte. `so_oe_o` is high only while select is low.
- R8: Raising SPI select partway through a byte discards that byte, so no register changes.
- R9: Bit 0 of register 0x70 disables the I2C decoder while it is set, so no address is acknowledged. Clearing the bit restores normal I2C operation.
- R10: Both interfaces reach the same register file, so a byte written through one can be read through the other. Every register reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sda_i | input | 1 | I2C data line level / SPI data in |
| scl_i | input | 1 | I2C clock / SPI clock |
| cs_n_i | input | 1 | SPI select, active low |
| strap_i | input | 1 | I2C address bit 0 strap level |
| sda_oe_o | output | 1 | High pulls the I2C data line low |
| so_o | output | 1 | SPI serial data out |
| so_oe_o | output | 1 | Output enable for the SPI data out pin |

## Verification
Every serial pin passes through two synchronizer flops, and one more register stage finds its edges. An ACK, a read bit or a release on the data line therefore appears three system clocks after the SCL falling edge that causes it. An SPI output bit likewise appears three clocks after the SCLK falling edge, and a register write lands about four clocks after the rising edge that completes its byte. The bench holds each quarter of an I2C bit and each half of an SPI bit for eight system clocks. It samples the data line just before the next clock edge it drives, which is always five or more clocks after a result is due. Address matching is swept over all 128 addresses, and data patterns are computed arithmetically from the register index.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] BITS_FULL = 4'd8;

  typedef enum logic [2:0] {
    I_IDLE, I_ADDR, I_ACK, I_PTR, I_WDAT, I_RDAT, I_RACK, I_SKIP
  } i2c_st_t;
endpackage

// File: rtl/dsr_sync.sv
module dsr_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic [1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {2{RST_VAL[b]}};
        else        stg_q <= {stg_q[0], d[b]};
      end
      assign q[b] = stg_q[1];
    end
  endgenerate
endmodule

// File: rtl/dsr_regs.sv
module dsr_regs #(
  parameter int ADDR_W   = 7,
  parameter int CFG_ADDR = 'h70,
  parameter int CFG_BIT  = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we_a,
  input  logic [ADDR_W-1:0]          waddr_a,
  input  logic [dsr_pkg::BYTE_W-1:0] wdata_a,
  input  logic                       we_b,
  input  logic [ADDR_W-1:0]          waddr_b,
  input  logic [dsr_pkg::BYTE_W-1:0] wdata_b,
  input  logic [ADDR_W-1:0]          raddr_a,
  output logic [dsr_pkg::BYTE_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0]          raddr_b,
  output logic [dsr_pkg::BYTE_W-1:0] rdata_b,
  output logic                       cfg_flag
);
  localparam int DW    = dsr_pkg::BYTE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH*DW-1:0] flat;

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic          hit_a, hit_b;
      logic [DW-1:0] ent_q, ent_d;
      assign hit_a = we_a && (waddr_a == ADDR_W'(e));
      assign hit_b = we_b && (waddr_b == ADDR_W'(e));
      always_comb begin
        ent_d = ent_q;
        if (hit_a)      ent_d = wdata_a;
        else if (hit_b) ent_d = wdata_b;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              ent_q <= '0;
        else if (hit_a || hit_b) ent_q <= ent_d;
      end
      assign flat[e*DW +: DW] = ent_q;
    end
  endgenerate

  assign rdata_a  = flat[raddr_a*DW +: DW];
  assign rdata_b  = flat[raddr_b*DW +: DW];
  assign cfg_flag = flat[CFG_ADDR*DW + CFG_BIT];
endmodule

// File: rtl/dsr_i2c.sv
module dsr_i2c #(
  parameter int ADDR_W = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       sda_s,
  input  logic                       sda_p,
  input  logic                       scl_s,
  input  logic                       scl_p,
  input  logic [6:0]                 dev_addr,
  input  logic [dsr_pkg::BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0]          ptr,
  output logic                       we,
  output logic [dsr_pkg::BYTE_W-1:0] wdata,
  output logic                       sda_oe,
  output logic                       busy
);
  import dsr_pkg::*;

  i2c_st_t          st_q, st_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d, out_q, out_d;
  logic             oe_d, rd_q, rd_d, gp_q, gp_d, mack_q, mack_d, busy_d;
  logic [ADDR_W-1:0] ptr_d;
  logic             start_c, stop_c, rise_c, fall_c;

  assign start_c = en && scl_s && scl_p && sda_p && !sda_s;
  assign stop_c  = en && scl_s && scl_p && !sda_p && sda_s;
  assign rise_c  = scl_s && !scl_p;
  assign fall_c  = !scl_s && scl_p;
  assign wdata   = sh_q;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; out_d = out_q;
    oe_d = sda_oe; ptr_d = ptr; rd_d = rd_q; gp_d = gp_q;
    mack_d = mack_q; busy_d = busy; we = 1'b0;
    if (!en) begin
      st_d = I_IDLE; oe_d = 1'b0; busy_d = 1'b0;
    end else if (start_c) begin
      st_d = I_ADDR; cnt_d = '0; oe_d = 1'b0; busy_d = 1'b1; gp_d = 1'b0;
    end else if (stop_c) begin
      st_d = I_IDLE; oe_d = 1'b0; busy_d = 1'b0;
    end else begin
      case (st_q)
        I_ADDR, I_PTR, I_WDAT: begin
          if (rise_c && (cnt_q != BITS_FULL)) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (fall_c && (cnt_q == BITS_FULL)) begin
            cnt_d = '0;
            if (st_q == I_ADDR) begin
              if (sh_q[7:1] == dev_addr) begin
                rd_d = sh_q[0]; oe_d = 1'b1; st_d = I_ACK;
              end else begin
                st_d = I_SKIP;
              end
            end else if (st_q == I_PTR) begin
              ptr_d = sh_q[ADDR_W-1:0]; gp_d = 1'b1; oe_d = 1'b1; st_d = I_ACK;
            end else begin
              we = 1'b1; ptr_d = ptr + 1'b1; oe_d = 1'b1; st_d = I_ACK;
            end
          end
        end
        I_ACK: begin
          if (fall_c) begin
            oe_d = 1'b0; cnt_d = '0;
            if (rd_q) begin
              out_d = {rd_data[BYTE_W-2:0], 1'b0};
              oe_d  = !rd_data[BYTE_W-1];
              ptr_d = ptr + 1'b1; cnt_d = 4'd1; st_d = I_RDAT;
            end else if (gp_q) begin
              st_d = I_WDAT;
            end else begin
              st_d = I_PTR;
            end
          end
        end
        I_RDAT: begin
          if (fall_c) begin
            if (cnt_q == BITS_FULL) begin
              oe_d = 1'b0; st_d = I_RACK;
            end else begin
              oe_d  = !out_q[BYTE_W-1];
              out_d = {out_q[BYTE_W-2:0], 1'b0};
              cnt_d = cnt_q + 4'd1;
            end
          end
        end
        I_RACK: begin
          if (rise_c) begin
            mack_d = !sda_s;
          end else if (fall_c) begin
            if (mack_q) begin
              out_d = {rd_data[BYTE_W-2:0], 1'b0};
              oe_d  = !rd_data[BYTE_W-1];
              ptr_d = ptr + 1'b1; cnt_d = 4'd1; st_d = I_RDAT;
            end else begin
              st_d = I_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= I_IDLE; cnt_q <= '0; sh_q <= '0; out_q <= '0; sda_oe <= 1'b0;
      ptr <= '0; rd_q <= 1'b0; gp_q <= 1'b0; mack_q <= 1'b0; busy <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; out_q <= out_d; sda_oe <= oe_d;
      ptr <= ptr_d; rd_q <= rd_d; gp_q <= gp_d; mack_q <= mack_d; busy <= busy_d;
    end
  end
endmodule

// File: rtl/dsr_spi.sv
module dsr_spi #(
  parameter int ADDR_W = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_s,
  input  logic                       sck_s,
  input  logic                       sck_p,
  input  logic                       mosi_s,
  input  logic [dsr_pkg::BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0]          ptr,
  output logic                       we,
  output logic [dsr_pkg::BYTE_W-1:0] wdata,
  output logic                       miso
);
  import dsr_pkg::*;

  logic [2:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d, out_q, out_d, shifted;
  logic              cmd_q, cmd_d, rd_q, rd_d, ld_q, ld_d, miso_d;
  logic [ADDR_W-1:0] ptr_d;
  logic              rise_c, fall_c;

  assign rise_c  = sck_s && !sck_p;
  assign fall_c  = !sck_s && sck_p;
  assign shifted = {sh_q[BYTE_W-2:0], mosi_s};
  assign wdata   = shifted;

  always_comb begin
    cnt_d = cnt_q; sh_d = sh_q; out_d = out_q; cmd_d = cmd_q; rd_d = rd_q;
    ld_d = 1'b0; miso_d = miso; ptr_d = ptr; we = 1'b0;
    if (cs_s) begin
      cnt_d = '0; cmd_d = 1'b0; out_d = '0; miso_d = 1'b0;
    end else begin
      if (ld_q) begin
        out_d = rd_data; ptr_d = ptr + 1'b1;
      end
      if (rise_c) begin
        sh_d  = shifted;
        cnt_d = cnt_q + 3'd1;
        if (cnt_q == 3'd7) begin
          if (!cmd_q) begin
            cmd_d = 1'b1;
            rd_d  = shifted[BYTE_W-1];
            ptr_d = shifted[ADDR_W-1:0];
            ld_d  = shifted[BYTE_W-1];
          end else if (rd_q) begin
            ld_d = 1'b1;
          end else begin
            we = 1'b1; ptr_d = ptr + 1'b1;
          end
        end
      end else if (fall_c) begin
        miso_d = out_q[BYTE_W-1];
        out_d  = {out_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; sh_q <= '0; out_q <= '0; cmd_q <= 1'b0; rd_q <= 1'b0;
      ld_q <= 1'b0; miso <= 1'b0; ptr <= '0;
    end else begin
      cnt_q <= cnt_d; sh_q <= sh_d; out_q <= out_d; cmd_q <= cmd_d; rd_q <= rd_d;
      ld_q <= ld_d; miso <= miso_d; ptr <= ptr_d;
    end
  end
endmodule

// File: rtl/dual_serial_regslave.sv
module dual_serial_regslave #(
  parameter int          ADDR_W   = 7,
  parameter int          CFG_ADDR = 'h70,
  parameter int          CFG_BIT  = 0,
  parameter logic [5:0]  DEV_HI   = 6'b110100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_i,
  input  logic scl_i,
  input  logic cs_n_i,
  input  logic strap_i,
  output logic sda_oe_o,
  output logic so_o,
  output logic so_oe_o
);
  localparam int DW = dsr_pkg::BYTE_W;

  logic [1:0] rst_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  logic sda_s, scl_s, cs_s, strap_s, sda_p, scl_p;
  dsr_sync #(.W(4), .RST_VAL(4'b1110)) i_sync (
    .clk(clk), .rst_n(rst_int_n),
    .d({sda_i, scl_i, cs_n_i, strap_i}),
    .q({sda_s, scl_s, cs_s, strap_s})
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sda_p <= 1'b1; scl_p <= 1'b1;
    end else begin
      sda_p <= sda_s; scl_p <= scl_s;
    end
  end

  logic              i2c_off, i2c_we, i2c_busy, spi_we;
  logic [ADDR_W-1:0] i2c_ptr, spi_ptr;
  logic [DW-1:0]     i2c_wd, spi_wd, i2c_rd, spi_rd;

  dsr_i2c #(.ADDR_W(ADDR_W)) i_i2c (
    .clk(clk), .rst_n(rst_int_n), .en(!i2c_off),
    .sda_s(sda_s), .sda_p(sda_p), .scl_s(scl_s), .scl_p(scl_p),
    .dev_addr({DEV_HI, strap_s}), .rd_data(i2c_rd),
    .ptr(i2c_ptr), .we(i2c_we), .wdata(i2c_wd),
    .sda_oe(sda_oe_o), .busy(i2c_busy)
  );

  dsr_spi #(.ADDR_W(ADDR_W)) i_spi (
    .clk(clk), .rst_n(rst_int_n), .cs_s(cs_s),
    .sck_s(scl_s), .sck_p(scl_p), .mosi_s(sda_s), .rd_data(spi_rd),
    .ptr(spi_ptr), .we(spi_we), .wdata(spi_wd), .miso(so_o)
  );

  dsr_regs #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .CFG_BIT(CFG_BIT)) i_regs (
    .clk(clk), .rst_n(rst_int_n),
    .we_a(spi_we), .waddr_a(spi_ptr), .wdata_a(spi_wd),
    .we_b(i2c_we), .waddr_b(i2c_ptr), .wdata_b(i2c_wd),
    .raddr_a(spi_ptr), .rdata_a(spi_rd),
    .raddr_b(i2c_ptr), .rdata_b(i2c_rd),
    .cfg_flag(i2c_off)
  );

  assign so_oe_o = !cs_s;
endmodule

// File: rtl/dsr_chk.sv
module dsr_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic scl_s,
  input logic cs_s,
  input logic i2c_off,
  input logic i2c_busy,
  input logic i2c_we,
  input logic spi_we
);
  AST_OE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> i2c_busy);  // R2
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));  // R3
  AST_I2C_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_we |-> i2c_busy);  // R5
  AST_SPI_WR_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_we |-> !cs_s);  // R8
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_off |=> !sda_oe);  // R9
endmodule

bind dual_serial_regslave dsr_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_s(scl_s), .cs_s(cs_s),
  .i2c_off(i2c_off), .i2c_busy(i2c_busy), .i2c_we(i2c_we), .spi_we(spi_we)
);

// File: tb/test_dual_serial_regslave.sv
module test_dual_serial_regslave;
  localparam int Q = 8;
  localparam int H = 8;
  localparam int LIMIT = 190000;

  logic clk, rst_n, sda_m, scl_m, cs_n, strap;
  logic sda_oe, so, so_oe, sda_line;
  int checks = 0, errors = 0;
  logic [7:0] rxb [8];

  assign sda_line = sda_m & ~sda_oe;

  dual_serial_regslave i_dual_serial_regslave (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_line), .scl_i(scl_m), .cs_n_i(cs_n),
    .strap_i(strap), .sda_oe_o(sda_oe), .so_o(so), .so_oe_o(so_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  task automatic i2c_start();
    sda_m = 1'b1; waitc(Q); scl_m = 1'b1; waitc(Q);
    sda_m = 1'b0; waitc(Q); scl_m = 1'b0; waitc(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; waitc(Q); scl_m = 1'b1; waitc(Q); sda_m = 1'b1; waitc(Q);
  endtask

  task automatic i2c_bit(input logic b);
    sda_m = b; waitc(Q); scl_m = 1'b1; waitc(2 * Q); scl_m = 1'b0; waitc(Q);
  endtask

  task automatic i2c_send(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) i2c_bit(v[i]);
    sda_m = 1'b1; waitc(Q); scl_m = 1'b1; waitc(Q);
    ack = ~sda_line; waitc(Q); scl_m = 1'b0; waitc(Q);
  endtask

  task automatic i2c_recv(input logic master_ack, output logic [7:0] v);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitc(Q); scl_m = 1'b1; waitc(Q); v[i] = sda_line; waitc(Q); scl_m = 1'b0;
    end
    waitc(Q);
    i2c_bit(~master_ack);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sda_m = tx[i]; waitc(H); rx[i] = so; scl_m = 1'b1; waitc(H); scl_m = 1'b0;
    end
  endtask

  task automatic spi_begin();
    scl_m = 1'b0; waitc(H); cs_n = 1'b0; waitc(H);
  endtask

  task automatic spi_end();
    waitc(H); cs_n = 1'b1; waitc(2 * H);
  endtask

  task automatic spi_write(input logic [6:0] a, input int n, input int base);
    logic [7:0] d;
    spi_begin();
    spi_byte({1'b0, a}, d);
    for (int k = 0; k < n; k++) spi_byte(pat(base + k), d);
    spi_end();
  endtask

  task automatic spi_read(input logic [6:0] a, input int n);
    logic [7:0] d;
    spi_begin();
    spi_byte({1'b1, a}, d);
    for (int k = 0; k < n; k++) spi_byte(8'h00, rxb[k]);
    spi_end();
  endtask

  task automatic spi_write1(input logic [6:0] a, input logic [7:0] v);
    logic [7:0] d;
    spi_begin(); spi_byte({1'b0, a}, d); spi_byte(v, d); spi_end();
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] v;
    rst_n = 1'b0; sda_m = 1'b1; scl_m = 1'b1; cs_n = 1'b1; strap = 1'b0;
    waitc(5); rst_n = 1'b1; waitc(10);

    chk("R10 reset sda_oe", int'(sda_oe), 0);
    chk("R7 reset so_oe", int'(so_oe), 0);
    spi_read(7'h20, 2);
    chk("R10 reset reg 0x20", int'(rxb[0]), 0);
    chk("R10 reset reg 0x21", int'(rxb[1]), 0);
    scl_m = 1'b1; waitc(Q);

    // R1 sweep over every 7-bit address with strap low
    for (int a = 0; a < 128; a++) begin
      i2c_start(); i2c_send({7'(a), 1'b0}, ack); i2c_stop();
      chk($sformatf("R1 addr 0x%0h", a), int'(ack), int'(a == 'h68));
    end
    strap = 1'b1; waitc(10);
    i2c_start(); i2c_send(8'hD2, ack); i2c_stop();
    chk("R1 strap high 0x69", int'(ack), 1);
    i2c_start(); i2c_send(8'hD0, ack); i2c_stop();
    chk("R1 strap high 0x68", int'(ack), 0);
    strap = 1'b0; waitc(10);

    // R2 no START: address bits clocked while idle are not acknowledged
    scl_m = 1'b0; waitc(Q);
    i2c_send(8'hD0, ack);
    chk("R2 no START no ack", int'(ack), 0);
    scl_m = 1'b1; waitc(Q); sda_m = 1'b1; waitc(Q);

    // R3 I2C write burst
    i2c_start(); i2c_send(8'hD0, ack); i2c_send(8'h10, ack);
    chk("R3 pointer ack", int'(ack), 1);
    for (int k = 0; k < 4; k++) begin
      i2c_send(pat(k), ack);
      chk("R3 data ack", int'(ack), 1);
    end
    i2c_stop();

    // R4 I2C read burst via repeated START
    i2c_start(); i2c_send(8'hD0, ack); i2c_send(8'h10, ack);
    i2c_start(); i2c_send(8'hD1, ack);
    chk("R4 read addr ack", int'(ack), 1);
    for (int k = 0; k < 4; k++) begin
      i2c_recv(k != 3, v);
      chk($sformatf("R4 read byte %0d", k), int'(v), int'(pat(k)));
    end
    waitc(2);
    chk("R4 released after NACK", int'(sda_oe), 0);
    i2c_stop();

    // R10 I2C-written data seen over SPI
    spi_read(7'h10, 4);
    for (int k = 0; k < 4; k++) chk("R10 SPI sees I2C data", int'(rxb[k]), int'(pat(k)));

    // R6 / R7 SPI write then read burst
    spi_write(7'h40, 6, 20);
    spi_begin();
    chk("R7 so_oe while selected", int'(so_oe), 1);
    spi_byte(8'hC0, v);
    for (int k = 0; k < 6; k++) spi_byte(8'h00, rxb[k]);
    spi_end();
    for (int k = 0; k < 6; k++) chk($sformatf("R6 R7 SPI byte %0d", k), int'(rxb[k]), int'(pat(20 + k)));
    chk("R7 so_oe after deselect", int'(so_oe), 0);

    // R10 SPI-written data seen over I2C
    scl_m = 1'b1; waitc(Q);
    i2c_start(); i2c_send(8'hD0, ack); i2c_send(8'h42, ack);
    i2c_start(); i2c_send(8'hD1, ack); i2c_recv(1'b0, v); i2c_stop();
    chk("R10 I2C sees SPI data", int'(v), int'(pat(22)));

    // R5 STOP mid-byte discards it
    i2c_start(); i2c_send(8'hD0, ack); i2c_send(8'h30, ack); i2c_send(8'hA5, ack);
    for (int k = 0; k < 4; k++) i2c_bit(1'b1);
    i2c_stop();
    spi_read(7'h30, 2);
    chk("R5 full byte stored", int'(rxb[0]), 'hA5);
    chk("R5 partial byte dropped", int'(rxb[1]), 0);

    // R8 deselect mid-byte discards it
    spi_begin(); spi_byte(8'h50, v);
    for (int k = 0; k < 4; k++) begin
      sda_m = 1'b1; waitc(H); scl_m = 1'b1; waitc(H); scl_m = 1'b0;
    end
    spi_end();
    spi_read(7'h50, 1);
    chk("R8 partial SPI byte dropped", int'(rxb[0]), 0);

    // R9 I2C disable bit
    spi_write1(7'h70, 8'h01);
    scl_m = 1'b1; waitc(Q);
    i2c_start(); i2c_send(8'hD0, ack); i2c_stop();
    chk("R9 disabled no ack", int'(ack), 0);
    spi_read(7'h70, 1);
    chk("R9 disable bit reads back", int'(rxb[0]), 1);
    spi_write1(7'h70, 8'h00);
    scl_m = 1'b1; waitc(Q);
    i2c_start(); i2c_send(8'hD0, ack); i2c_stop();
    chk("R9 re-enabled ack", int'(ack), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule